// File: doc/BRIEF.md
# AXI-Lite Transaction Timeout Guard

This block sits between an AXI-Lite master and the slave it talks to and keeps each direction down to one transaction in flight. A cycle counter runs for each transaction. When the slave answers in time, handshakes, data and response codes pass through untouched. When a write or read stays unfinished for the configured number of cycles, the guard cuts the slave off. It accepts whatever address or data beats the master still has pending, then answers the master itself with an error response. A master attached to a dead or hung slave therefore always gets an answer and can carry on.

Writes and reads have separate counters, so a stall in one direction never shortens or lengthens the window of the other. A counter pauses while the slave's response is waiting for the master's ready, so a slow master never turns a good answer into an error. Response codes are 2'b00 for OKAY and 2'b10 for SLVERR.

Top module: `axil_timeout_guard`

## Requirements
- R1: A write whose slave-side B response appears before the limit reaches the master with its response code unchanged, including codes other than OKAY (for example 2'b11).
- R2: A read whose slave-side R response appears before the limit reaches the master with its read data and response code unchanged.
- R3: Cycle 0 of a write is the first cycle in which the master drives AW or W valid. If the slave has not raised B valid by cycle TIMEOUT_CYCLES-1, then in cycle TIMEOUT_CYCLES the guard raises AW and W ready for every beat not yet accepted. One cycle after both beats have been accepted, it presents B valid with SLVERR (2'b10). A slave B valid arriving in cycle TIMEOUT_CYCLES-1 still passes through as in R1.
- R4: Cycle 0 of a read is the first cycle in which AR valid is high. If the slave has not raised R valid by cycle TIMEOUT_CYCLES-1, then in cycle TIMEOUT_CYCLES the guard raises AR ready, and one cycle after the AR handshake it presents R valid with SLVERR (2'b10) and data of all ones. A slave R valid arriving in cycle TIMEOUT_CYCLES-1 still passes through as in R2.
- R5: Once B valid or R valid is shown to the master, it stays high with a stable response (and read data) until the master's ready is seen.
- R6: After an error response has completed, the next transaction in that direction is forwarded to the slave and completes normally.
- R7: The write counter and the read counter are independent: a stalled read does not make a concurrent write time out earlier, and a write does not stop the read from timing out.
- R8: A response that the slave has already raised is never replaced by an error, however long the master holds its ready low.
- R9: While the guard is answering a timed-out transaction, it drives the slave-facing valid of that direction low.
- R10: After reset, with all inputs low, the master-facing B and R valids and the slave-facing AW, W and AR valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awvalid_i | input | 1 | Master write-address valid |
| s_awready_o | output | 1 | Write-address ready to the master |
| s_awaddr_i | input | ADDR_W | Master write address |
| s_wvalid_i | input | 1 | Master write-data valid |
| s_wready_o | output | 1 | Write-data ready to the master |
| s_wdata_i | input | DATA_W | Master write data |
| s_wstrb_i | input | DATA_W/8 | Master write byte strobes |
| s_bvalid_o | output | 1 | Write-response valid to the master |
| s_bready_i | input | 1 | Master write-response ready |
| s_bresp_o | output | 2 | Write response to the master |
| s_arvalid_i | input | 1 | Master read-address valid |
| s_arready_o | output | 1 | Read-address ready to the master |
| s_araddr_i | input | ADDR_W | Master read address |
| s_rvalid_o | output | 1 | Read-data valid to the master |
| s_rready_i | input | 1 | Master read-data ready |
| s_rdata_o | output | DATA_W | Read data to the master |
| s_rresp_o | output | 2 | Read response to the master |
| m_awvalid_o | output | 1 | Write-address valid to the slave |
| m_awready_i | input | 1 | Slave write-address ready |
| m_awaddr_o | output | ADDR_W | Write address to the slave |
| m_wvalid_o | output | 1 | Write-data valid to the slave |
| m_wready_i | input | 1 | Slave write-data ready |
| m_wdata_o | output | DATA_W | Write data to the slave |
| m_wstrb_o | output | DATA_W/8 | Write byte strobes to the slave |
| m_bvalid_i | input | 1 | Slave write-response valid |
| m_bready_o | output | 1 | Write-response ready to the slave |
| m_bresp_i | input | 2 | Slave write response |
| m_arvalid_o | output | 1 | Read-address valid to the slave |
| m_arready_i | input | 1 | Slave read-address ready |
| m_araddr_o | output | ADDR_W | Read address to the slave |
| m_rvalid_i | input | 1 | Slave read-data valid |
| m_rready_o | output | 1 | Read-data ready to the slave |
| m_rdata_i | input | DATA_W | Slave read data |
| m_rresp_i | input | 2 | Slave read response |

## Verification
The bench sweeps the cycle in which the slave answers, for both writes and reads, from one cycle up to past the limit. An off-by-one counter shows up there as a good answer turned into SLVERR, or as a late answer let through. A fully dead slave checks the exact cycle at which the guard takes over the address handshake, and that the slave-facing valid drops at that point. A guard missing that step would leave the master hanging or keep offering the beat to the slave. A master that holds its ready low checks that pending responses neither change nor expire. A read stalled across a boundary-timed write catches a counter shared between the two directions, and normal traffic after each error catches a guard that stays stuck in its error state.

// File: rtl/axil_tg_pkg.sv
package axil_tg_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic expire_o
);
  localparam int unsigned CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i & (cnt_q == LAST);
endmodule

// File: rtl/wr_guard.sv
module wr_guard
  import axil_tg_pkg::*;
#(
  parameter int unsigned LIMIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       s_awvalid_i,
  output logic       s_awready_o,
  input  logic       s_wvalid_i,
  output logic       s_wready_o,
  output logic       s_bvalid_o,
  input  logic       s_bready_i,
  output logic [1:0] s_bresp_o,
  output logic       m_awvalid_o,
  input  logic       m_awready_i,
  output logic       m_wvalid_o,
  input  logic       m_wready_i,
  input  logic       m_bvalid_i,
  output logic       m_bready_o,
  input  logic [1:0] m_bresp_i
);
  logic aw_seen_q, w_seen_q, err_q;
  logic busy, run, b_done, expire;

  // one write in flight; error mode isolates the slave and accepts beats locally
  assign m_awvalid_o = s_awvalid_i & ~aw_seen_q & ~err_q;
  assign m_wvalid_o  = s_wvalid_i  & ~w_seen_q  & ~err_q;
  assign s_awready_o = ~aw_seen_q & (err_q | m_awready_i);
  assign s_wready_o  = ~w_seen_q  & (err_q | m_wready_i);
  assign s_bvalid_o  = err_q ? (aw_seen_q & w_seen_q) : m_bvalid_i;
  assign s_bresp_o   = err_q ? RESP_SLVERR : m_bresp_i;
  assign m_bready_o  = err_q | s_bready_i;   // sink any late slave response

  assign b_done = s_bvalid_o & s_bready_i;
  assign busy   = s_awvalid_i | s_wvalid_i | aw_seen_q | w_seen_q;
  assign run    = busy & ~err_q & ~m_bvalid_i;

  guard_timer #(.LIMIT(LIMIT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .clr_i    (b_done | ~busy),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_seen_q <= 1'b0;
      w_seen_q  <= 1'b0;
      err_q     <= 1'b0;
    end else if (b_done) begin
      aw_seen_q <= 1'b0;
      w_seen_q  <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (s_awvalid_i & s_awready_o) aw_seen_q <= 1'b1;
      if (s_wvalid_i & s_wready_o)   w_seen_q  <= 1'b1;
      if (expire)                    err_q     <= 1'b1;
    end
  end

  a_r5_b_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_bvalid_o && !s_bready_i) |=> (s_bvalid_o && $stable(s_bresp_o)));
  a_r8_b_pending_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_bvalid_i && !err_q) |=> !err_q);
  a_r6_wr_err_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && s_bvalid_o && s_bready_i) |=> !err_q);
  a_r3_wr_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(s_awvalid_i || s_wvalid_i || aw_seen_q || w_seen_q));
endmodule

// File: rtl/rd_guard.sv
module rd_guard
  import axil_tg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LIMIT  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i,
  output logic [DATA_W-1:0] s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              m_arvalid_o,
  input  logic              m_arready_i,
  input  logic              m_rvalid_i,
  output logic              m_rready_o,
  input  logic [DATA_W-1:0] m_rdata_i,
  input  logic [1:0]        m_rresp_i
);
  logic ar_seen_q, err_q;
  logic busy, run, r_done, expire;

  assign m_arvalid_o = s_arvalid_i & ~ar_seen_q & ~err_q;
  assign s_arready_o = ~ar_seen_q & (err_q | m_arready_i);
  assign s_rvalid_o  = err_q ? ar_seen_q : m_rvalid_i;
  assign s_rresp_o   = err_q ? RESP_SLVERR : m_rresp_i;
  assign s_rdata_o   = err_q ? {DATA_W{1'b1}} : m_rdata_i;
  assign m_rready_o  = err_q | s_rready_i;

  assign r_done = s_rvalid_o & s_rready_i;
  assign busy   = s_arvalid_i | ar_seen_q;
  assign run    = busy & ~err_q & ~m_rvalid_i;

  guard_timer #(.LIMIT(LIMIT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .clr_i    (r_done | ~busy),
    .expire_o (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ar_seen_q <= 1'b0;
      err_q     <= 1'b0;
    end else if (r_done) begin
      ar_seen_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (s_arvalid_i & s_arready_o) ar_seen_q <= 1'b1;
      if (expire)                    err_q     <= 1'b1;
    end
  end

  a_r5_r_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_rvalid_o && !s_rready_i) |=> (s_rvalid_o && $stable(s_rresp_o) && $stable(s_rdata_o)));
  a_r8_r_pending_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_rvalid_i && !err_q) |=> !err_q);
  a_r6_rd_err_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && s_rvalid_o && s_rready_i) |=> !err_q);
  a_r4_rd_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(s_arvalid_i || ar_seen_q));
endmodule

// File: rtl/axil_timeout_guard.sv
module axil_timeout_guard #(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned TIMEOUT_CYCLES = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                s_awvalid_i,
  output logic                s_awready_o,
  input  logic [ADDR_W-1:0]   s_awaddr_i,
  input  logic                s_wvalid_i,
  output logic                s_wready_o,
  input  logic [DATA_W-1:0]   s_wdata_i,
  input  logic [DATA_W/8-1:0] s_wstrb_i,
  output logic                s_bvalid_o,
  input  logic                s_bready_i,
  output logic [1:0]          s_bresp_o,
  input  logic                s_arvalid_i,
  output logic                s_arready_o,
  input  logic [ADDR_W-1:0]   s_araddr_i,
  output logic                s_rvalid_o,
  input  logic                s_rready_i,
  output logic [DATA_W-1:0]   s_rdata_o,
  output logic [1:0]          s_rresp_o,
  output logic                m_awvalid_o,
  input  logic                m_awready_i,
  output logic [ADDR_W-1:0]   m_awaddr_o,
  output logic                m_wvalid_o,
  input  logic                m_wready_i,
  output logic [DATA_W-1:0]   m_wdata_o,
  output logic [DATA_W/8-1:0] m_wstrb_o,
  input  logic                m_bvalid_i,
  output logic                m_bready_o,
  input  logic [1:0]          m_bresp_i,
  output logic                m_arvalid_o,
  input  logic                m_arready_i,
  output logic [ADDR_W-1:0]   m_araddr_o,
  input  logic                m_rvalid_i,
  output logic                m_rready_o,
  input  logic [DATA_W-1:0]   m_rdata_i,
  input  logic [1:0]          m_rresp_i
);
  assign m_awaddr_o = s_awaddr_i;
  assign m_wdata_o  = s_wdata_i;
  assign m_wstrb_o  = s_wstrb_i;
  assign m_araddr_o = s_araddr_i;

  wr_guard #(.LIMIT(TIMEOUT_CYCLES)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .s_awvalid_i (s_awvalid_i),
    .s_awready_o (s_awready_o),
    .s_wvalid_i  (s_wvalid_i),
    .s_wready_o  (s_wready_o),
    .s_bvalid_o  (s_bvalid_o),
    .s_bready_i  (s_bready_i),
    .s_bresp_o   (s_bresp_o),
    .m_awvalid_o (m_awvalid_o),
    .m_awready_i (m_awready_i),
    .m_wvalid_o  (m_wvalid_o),
    .m_wready_i  (m_wready_i),
    .m_bvalid_i  (m_bvalid_i),
    .m_bready_o  (m_bready_o),
    .m_bresp_i   (m_bresp_i)
  );

  rd_guard #(.DATA_W(DATA_W), .LIMIT(TIMEOUT_CYCLES)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .s_arvalid_i (s_arvalid_i),
    .s_arready_o (s_arready_o),
    .s_rvalid_o  (s_rvalid_o),
    .s_rready_i  (s_rready_i),
    .s_rdata_o   (s_rdata_o),
    .s_rresp_o   (s_rresp_o),
    .m_arvalid_o (m_arvalid_o),
    .m_arready_i (m_arready_i),
    .m_rvalid_i  (m_rvalid_i),
    .m_rready_o  (m_rready_o),
    .m_rdata_i   (m_rdata_i),
    .m_rresp_i   (m_rresp_i)
  );
endmodule

// File: tb/tb_axil_timeout_guard.sv
module tb_axil_timeout_guard;
  localparam int LIM = 16;
  localparam int NEVER = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [31:0] s_awaddr = 32'h100, s_wdata = 32'h55, s_araddr = 32'h200;
  logic [3:0]  s_wstrb = 4'hf;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic m_awready = 0, m_wready = 0, m_bvalid = 0, m_arready = 0, m_rvalid = 0;
  logic [1:0] m_bresp = 0, m_rresp = 0;
  logic [31:0] m_rdata = 0;
  logic m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
  logic [31:0] m_awaddr, m_wdata, m_araddr;
  logic [3:0]  m_wstrb;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  axil_timeout_guard #(.ADDR_W(32), .DATA_W(32), .TIMEOUT_CYCLES(LIM)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .s_awvalid_i(s_awvalid), .s_awready_o(s_awready), .s_awaddr_i(s_awaddr),
    .s_wvalid_i(s_wvalid), .s_wready_o(s_wready), .s_wdata_i(s_wdata), .s_wstrb_i(s_wstrb),
    .s_bvalid_o(s_bvalid), .s_bready_i(s_bready), .s_bresp_o(s_bresp),
    .s_arvalid_i(s_arvalid), .s_arready_o(s_arready), .s_araddr_i(s_araddr),
    .s_rvalid_o(s_rvalid), .s_rready_i(s_rready), .s_rdata_o(s_rdata), .s_rresp_o(s_rresp),
    .m_awvalid_o(m_awvalid), .m_awready_i(m_awready), .m_awaddr_o(m_awaddr),
    .m_wvalid_o(m_wvalid), .m_wready_i(m_wready), .m_wdata_o(m_wdata), .m_wstrb_o(m_wstrb),
    .m_bvalid_i(m_bvalid), .m_bready_o(m_bready), .m_bresp_i(m_bresp),
    .m_arvalid_o(m_arvalid), .m_arready_i(m_arready), .m_araddr_o(m_araddr),
    .m_rvalid_i(m_rvalid), .m_rready_o(m_rready), .m_rdata_i(m_rdata), .m_rresp_i(m_rresp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write; cycle 0 = first cycle with AW/W valid
  task automatic wr_txn(input int acc_at, input int b_at, input int brdy_at, input logic [1:0] sresp,
                        output logic [1:0] resp, output int aw_cyc, output int b_cyc,
                        output bit held, output bit iso);
    bit aw_acc = 0, w_acc = 0, sb_done = 0, seen_b = 0, done = 0;
    resp = 2'bxx; aw_cyc = -1; b_cyc = -1; held = 1; iso = 1;
    for (int cyc = 0; cyc < 200; cyc++) begin
      @(negedge clk);
      s_awvalid = !aw_acc; s_wvalid = !w_acc; s_bready = (cyc >= brdy_at);
      m_awready = (cyc >= acc_at); m_wready = (cyc >= acc_at);
      m_bvalid = (cyc >= b_at) && !sb_done; m_bresp = sresp;
      #1;
      if (seen_b && !s_bvalid) held = 0;
      if (s_bvalid) seen_b = 1;
      if (cyc >= LIM && acc_at >= NEVER && (m_awvalid || m_wvalid)) iso = 0;
      if (s_awvalid && s_awready) begin aw_acc = 1; aw_cyc = cyc; end
      if (s_wvalid && s_wready) w_acc = 1;
      if (m_bvalid && m_bready) sb_done = 1;
      if (s_bvalid && s_bready) begin resp = s_bresp; b_cyc = cyc; done = 1; end
      if (done) break;
    end
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0; s_bready = 0; m_awready = 0; m_wready = 0; m_bvalid = 0;
  endtask

  task automatic rd_txn(input int acc_at, input int r_at, input int rrdy_at, input logic [1:0] sresp,
                        input logic [31:0] sdata, output logic [1:0] resp, output logic [31:0] data,
                        output int ar_cyc, output int r_cyc, output bit held, output bit iso);
    bit ar_acc = 0, sr_done = 0, seen_r = 0, done = 0;
    resp = 2'bxx; data = 'x; ar_cyc = -1; r_cyc = -1; held = 1; iso = 1;
    for (int cyc = 0; cyc < 200; cyc++) begin
      @(negedge clk);
      s_arvalid = !ar_acc; s_rready = (cyc >= rrdy_at);
      m_arready = (cyc >= acc_at);
      m_rvalid = (cyc >= r_at) && !sr_done; m_rresp = sresp; m_rdata = sdata;
      #1;
      if (seen_r && !s_rvalid) held = 0;
      if (s_rvalid) seen_r = 1;
      if (cyc >= LIM && acc_at >= NEVER && m_arvalid) iso = 0;
      if (s_arvalid && s_arready) begin ar_acc = 1; ar_cyc = cyc; end
      if (m_rvalid && m_rready) sr_done = 1;
      if (s_rvalid && s_rready) begin resp = s_rresp; data = s_rdata; r_cyc = cyc; done = 1; end
      if (done) break;
    end
    @(negedge clk);
    s_arvalid = 0; s_rready = 0; m_arready = 0; m_rvalid = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] resp; logic [31:0] data;
    int c1, c2; bit held, iso;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R10 reset state
    chk(!s_bvalid && !s_rvalid, "R10 master valids", {30'b0, s_bvalid, s_rvalid}, 0);
    chk(!m_awvalid && !m_wvalid && !m_arvalid, "R10 slave valids",
        {29'b0, m_awvalid, m_wvalid, m_arvalid}, 0);

    // R1/R3 write sweep of slave answer cycle
    for (int k = 1; k <= LIM + 2; k++) begin
      wr_txn(0, k, 0, 2'b00, resp, c1, c2, held, iso);
      if (k <= LIM - 1) begin
        chk(resp == 2'b00, "R1 write okay passes", {30'b0, resp}, 0);
        chk(c2 == k, "R1 write answer cycle", 32'(c2), 32'(k));
      end else begin
        chk(resp == 2'b10, "R3 write slverr", {30'b0, resp}, 2);
        chk(c2 == LIM, "R3 write error cycle", 32'(c2), 32'(LIM));
      end
    end
    // R1 other response code unchanged
    wr_txn(2, 5, 0, 2'b11, resp, c1, c2, held, iso);
    chk(resp == 2'b11, "R1 decerr unchanged", {30'b0, resp}, 3);

    // R3/R9 dead slave write
    wr_txn(NEVER, NEVER, 0, 2'b00, resp, c1, c2, held, iso);
    chk(c1 == LIM, "R3 aw taken at limit", 32'(c1), 32'(LIM));
    chk(c2 == LIM + 1, "R3 b after accept", 32'(c2), 32'(LIM + 1));
    chk(resp == 2'b10, "R3 dead slverr", {30'b0, resp}, 2);
    chk(iso, "R9 write isolated", 32'(iso), 1);
    // R6 recovery
    wr_txn(1, 3, 0, 2'b00, resp, c1, c2, held, iso);
    chk(resp == 2'b00 && c2 == 3, "R6 write after error", {30'b0, resp}, 0);

    // R5 hold of error B
    wr_txn(NEVER, NEVER, LIM + 6, 2'b00, resp, c1, c2, held, iso);
    chk(held && resp == 2'b10 && c2 == LIM + 6, "R5 error B held", 32'(c2), 32'(LIM + 6));
    // R8 pending slave B with slow master
    wr_txn(0, 2, LIM + 4, 2'b00, resp, c1, c2, held, iso);
    chk(held && resp == 2'b00, "R8 write pending kept", {30'b0, resp}, 0);

    // R2/R4 read sweep
    for (int k = 1; k <= LIM + 2; k++) begin
      rd_txn(0, k, 0, 2'b00, 32'h1000_0000 + 32'(k), resp, data, c1, c2, held, iso);
      if (k <= LIM - 1) begin
        chk(resp == 2'b00, "R2 read okay passes", {30'b0, resp}, 0);
        chk(data == 32'h1000_0000 + 32'(k), "R2 read data", data, 32'h1000_0000 + 32'(k));
      end else begin
        chk(resp == 2'b10, "R4 read slverr", {30'b0, resp}, 2);
        chk(data == 32'hffff_ffff, "R4 read all ones", data, 32'hffff_ffff);
        chk(c2 == LIM, "R4 read error cycle", 32'(c2), 32'(LIM));
      end
    end
    // R4/R9 dead slave read, R5 hold
    rd_txn(NEVER, NEVER, LIM + 5, 2'b00, 0, resp, data, c1, c2, held, iso);
    chk(c1 == LIM, "R4 ar taken at limit", 32'(c1), 32'(LIM));
    chk(c2 == LIM + 5 && held, "R5 error R held", 32'(c2), 32'(LIM + 5));
    chk(iso, "R9 read isolated", 32'(iso), 1);
    // R6 read recovery
    rd_txn(0, 2, 0, 2'b01, 32'hcafe_0001, resp, data, c1, c2, held, iso);
    chk(resp == 2'b01 && data == 32'hcafe_0001, "R6 read after error", data, 32'hcafe_0001);
    // R8 read pending with slow master
    rd_txn(0, 3, LIM + 4, 2'b00, 32'h1234_5678, resp, data, c1, c2, held, iso);
    chk(resp == 2'b00 && data == 32'h1234_5678, "R8 read pending kept", data, 32'h1234_5678);

    // R7 stalled read alongside a boundary-timed write
    @(negedge clk);
    s_arvalid = 1; s_rready = 0; m_arready = 0; m_rvalid = 0;
    wr_txn(0, LIM - 1, 0, 2'b00, resp, c1, c2, held, iso);
    chk(resp == 2'b00, "R7 write unaffected by read stall", {30'b0, resp}, 0);
    c1 = 0;
    for (int i = 0; i < 40; i++) begin
      #1;
      if (s_rvalid) break;
      @(negedge clk);
      c1++;
    end
    #1;
    chk(s_rvalid && s_rresp == 2'b10 && s_rdata == 32'hffff_ffff, "R7 read still times out",
        s_rdata, 32'hffff_ffff);
    @(negedge clk);
    s_arvalid = 0; s_rready = 1;
    @(negedge clk);
    s_rready = 0;
    #1;
    chk(!s_rvalid, "R7 read error retired", 32'(s_rvalid), 0);
    rd_txn(0, 1, 0, 2'b00, 32'h0bad_f00d, resp, data, c1, c2, held, iso);
    chk(resp == 2'b00 && data == 32'h0bad_f00d, "R6 read after concurrent error", data, 32'h0bad_f00d);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule